// File: doc/BRIEF.md
# Single-Stream DMA Transfer Engine

This block is one DMA stream. It copies a run of data items between a peripheral address and a memory address. It uses two simple bus ports, one for reads and one for writes, and each port has a request/ready handshake. Software loads a configuration while the stream is disabled: direction, the item size on each side, an increment flag for each side, both start addresses and an item count. Software then sets the enable bit. While the stream is enabled and the trigger input is high, the stream moves one item per step:

1. It reads one item from the source.
2. It resizes the item to the destination width, padding or truncating as needed.
3. It writes the item to the destination.
4. It decrements the count and advances each address that has its increment flag set.

When the count reaches zero the stream clears its own enable bit and raises a one-cycle done pulse.

The peripheral side and the memory side each have their own item size. Each address advances by the size of its own side. The bus is 32 bits wide and little-endian. Read data arrives with the addressed item in the low bits. Write data and byte enables are placed on the byte lanes given by the low two bits of the destination address.

Top module: `dma_stream`

## Requirements
- R1: After reset the stream is disabled, the count and both addresses read back as zero, and no read request, write request or done is asserted.
- R2: A step starts only when all three of these hold: enable is 1, the count is non-zero and trig is 1. With a zero count, a clear enable or a low trig, no read request is issued.
- R3: When direction is 1 (memory to peripheral), the read uses the memory address and memory size, and the write uses the peripheral address. When direction is 0 the roles are swapped. rd_size carries the source size code.
- R4: Size codes are 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, and 11 is treated as 4 bytes. The written item is the low source-size bytes of rd_data, cut to the destination size. A narrower source item is zero-padded in its upper bytes. A wider source item keeps only its lowest-addressed bytes.
- R5: wr_data is the item shifted left by 8 × wr_addr[1:0] bits. wr_be is 4'b0001, 4'b0011 or 4'b1111 (for 1, 2 or 4 bytes), shifted left by wr_addr[1:0] and cut to 4 bits.
- R6: rd_req stays high with a stable address until rd_ready is sampled. Only then is wr_req raised. While either request is waiting, the count and the addresses do not change.
- R7: Each completed write handshake decrements the count by exactly one.
- R8: After each item, a side whose increment flag is set advances its address by that side's item size. A side whose flag is clear keeps its address.
- R9: The write handshake that brings the count to zero also clears enable. done is high for exactly one cycle, in the cycle after that handshake.
- R10: While enable is set, or while an item is in flight, a configuration write changes only the enable bit. While the stream is idle and disabled, a configuration write loads every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value to write |
| cfg_dir | input | 1 | 1 = memory to peripheral, 0 = peripheral to memory |
| cfg_psize | input | 2 | Peripheral item size code |
| cfg_msize | input | 2 | Memory item size code |
| cfg_pinc | input | 1 | Peripheral address increment flag |
| cfg_minc | input | 1 | Memory address increment flag |
| cfg_paddr | input | AW | Peripheral start address |
| cfg_maddr | input | AW | Memory start address |
| cfg_count | input | CW | Number of items |
| trig | input | 1 | Transfer trigger |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read size code |
| rd_ready | input | 1 | Read data valid / read accepted |
| rd_data | input | 32 | Read data, item in the low bits |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Lane-placed write data |
| wr_be | output | 4 | Byte enables |
| wr_ready | input | 1 | Write accepted |
| st_en | output | 1 | Current enable bit |
| st_paddr | output | AW | Current peripheral address |
| st_maddr | output | AW | Current memory address |
| st_count | output | CW | Items remaining |
| done | output | 1 | One-cycle pulse when the stream auto-disables |

## Verification
The bench runs streams in both directions and covers four size cases: widening, truncating, equal sizes, and byte-to-halfword. Destination addresses use unaligned lane offsets, so a design that leaks stale upper bytes, keeps the wrong end of a wide item or misplaces the byte lanes writes a value the scoreboard does not expect. Each run mixes increment flags and adds read and write latency. This catches an address that advances by the other side's size, or that advances when its flag is clear. It also catches a count that changes while a request is still waiting for ready. Separate cases enable a stream with a zero count, hold trig low, and write configuration while the stream is enabled. A design that gets these wrong issues a stray bus read or silently replaces its addresses in mid-run.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  // size code: 00 one byte, 01 two bytes, otherwise four bytes
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   size_bytes = 3'd1;
      2'b01:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] code);
    case (code)
      2'b00:   size_mask = 32'h0000_00FF;
      2'b01:   size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [LANES-1:0] size_be(input logic [1:0] code);
    case (code)
      2'b00:   size_be = 4'b0001;
      2'b01:   size_be = 4'b0011;
      default: size_be = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_stream_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_en,
  input  logic          cfg_dir,
  input  logic [1:0]    cfg_psize,
  input  logic [1:0]    cfg_msize,
  input  logic          cfg_pinc,
  input  logic          cfg_minc,
  input  logic [AW-1:0] cfg_paddr,
  input  logic [AW-1:0] cfg_maddr,
  input  logic [CW-1:0] cfg_count,
  input  logic          busy,
  input  logic          step_done,
  output logic          en,
  output logic          dir,
  output logic [1:0]    psize,
  output logic [1:0]    msize,
  output logic [AW-1:0] paddr,
  output logic [AW-1:0] maddr,
  output logic [CW-1:0] count,
  output logic          done
);
  logic          en_q, dir_q, pinc_q, minc_q, done_q;
  logic [1:0]    psize_q, msize_q;
  logic [AW-1:0] paddr_q, maddr_q;
  logic [CW-1:0] count_q;

  logic          en_n, done_n;
  logic [AW-1:0] paddr_n, maddr_n;
  logic [CW-1:0] count_n;
  logic          field_ld;   // clock enable for static fields
  logic          last_item;

  assign field_ld  = cfg_wr && !en_q && !busy;
  assign last_item = step_done && (count_q == CW'(1));

  always_comb begin
    en_n    = en_q;
    paddr_n = paddr_q;
    maddr_n = maddr_q;
    count_n = count_q;
    done_n  = 1'b0;
    if (cfg_wr) en_n = cfg_en;
    if (field_ld) begin
      paddr_n = cfg_paddr;
      maddr_n = cfg_maddr;
      count_n = cfg_count;
    end
    if (step_done) begin
      count_n = count_q - CW'(1);
      if (pinc_q) paddr_n = paddr_q + AW'(size_bytes(psize_q));
      if (minc_q) maddr_n = maddr_q + AW'(size_bytes(msize_q));
    end
    if (last_item) begin
      en_n   = 1'b0;
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      paddr_q <= '0;
      maddr_q <= '0;
      count_q <= '0;
    end else begin
      en_q    <= en_n;
      done_q  <= done_n;
      paddr_q <= paddr_n;
      maddr_q <= maddr_n;
      count_q <= count_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      pinc_q  <= 1'b0;
      minc_q  <= 1'b0;
      psize_q <= 2'b00;
      msize_q <= 2'b00;
    end else if (field_ld) begin
      dir_q   <= cfg_dir;
      pinc_q  <= cfg_pinc;
      minc_q  <= cfg_minc;
      psize_q <= cfg_psize;
      msize_q <= cfg_msize;
    end
  end

  assign en    = en_q;
  assign dir   = dir_q;
  assign psize = psize_q;
  assign msize = msize_q;
  assign paddr = paddr_q;
  assign maddr = maddr_q;
  assign count = count_q;
  assign done  = done_q;

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> count_q == $past(count_q) - CW'(1));
  // R9
  done_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !en_q);
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_stream_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic count_nz,
  input  logic trig,
  input  logic rd_ready,
  input  logic wr_ready,
  output logic rd_req,
  output logic wr_req,
  output logic capture,
  output logic step_done,
  output logic busy
);
  xfer_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE:  if (en && count_nz && trig) state_n = ST_READ;
      ST_READ:  if (rd_ready) state_n = ST_WRITE;
      ST_WRITE: if (wr_ready) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  assign rd_req    = (state_q == ST_READ);
  assign wr_req    = (state_q == ST_WRITE);
  assign capture   = rd_req && rd_ready;
  assign step_done = wr_req && wr_ready;
  assign busy      = (state_q != ST_IDLE);

  // R6
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, wr_req}));
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ready |=> rd_req);
  // R6
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ready |=> wr_req);
endmodule

// File: rtl/dma_resize.sv
module dma_resize
  import dma_stream_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic [1:0]        psize,
  input  logic [1:0]        msize,
  input  logic [AW-1:0]     paddr,
  input  logic [AW-1:0]     maddr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              capture,
  output logic [AW-1:0]     rd_addr,
  output logic [1:0]        rd_size,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_be
);
  logic [1:0]        src_sz, dst_sz;
  logic [DATA_W-1:0] item_n, item_q;
  logic [1:0]        lane;

  assign src_sz  = dir ? msize : psize;
  assign dst_sz  = dir ? psize : msize;
  assign rd_addr = dir ? maddr : paddr;
  assign wr_addr = dir ? paddr : maddr;
  assign rd_size = src_sz;
  assign lane    = wr_addr[1:0];

  // keep the low source bytes, then cut to destination width; pads with zero
  assign item_n = rd_data & size_mask(src_sz) & size_mask(dst_sz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       item_q <= '0;
    else if (capture) item_q <= item_n;
  end

  assign wr_data = item_q << {lane, 3'b000};
  assign wr_be   = size_be(dst_sz) << lane;
endmodule

// File: rtl/dma_stream.sv
module dma_stream
  import dma_stream_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_dir,
  input  logic [1:0]        cfg_psize,
  input  logic [1:0]        cfg_msize,
  input  logic              cfg_pinc,
  input  logic              cfg_minc,
  input  logic [AW-1:0]     cfg_paddr,
  input  logic [AW-1:0]     cfg_maddr,
  input  logic [CW-1:0]     cfg_count,
  input  logic              trig,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic [1:0]        rd_size,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_be,
  input  logic              wr_ready,
  output logic              st_en,
  output logic [AW-1:0]     st_paddr,
  output logic [AW-1:0]     st_maddr,
  output logic [CW-1:0]     st_count,
  output logic              done
);
  logic       dir, busy, capture, step_done;
  logic [1:0] psize, msize;

  dma_cfg_regs #(.AW(AW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_dir(cfg_dir), .cfg_psize(cfg_psize), .cfg_msize(cfg_msize),
    .cfg_pinc(cfg_pinc), .cfg_minc(cfg_minc), .cfg_paddr(cfg_paddr),
    .cfg_maddr(cfg_maddr), .cfg_count(cfg_count), .busy(busy),
    .step_done(step_done), .en(st_en), .dir(dir), .psize(psize),
    .msize(msize), .paddr(st_paddr), .maddr(st_maddr), .count(st_count),
    .done(done)
  );

  dma_xfer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(st_en), .count_nz(st_count != '0),
    .trig(trig), .rd_ready(rd_ready), .wr_ready(wr_ready),
    .rd_req(rd_req), .wr_req(wr_req), .capture(capture),
    .step_done(step_done), .busy(busy)
  );

  dma_resize #(.AW(AW)) u_resize (
    .clk(clk), .rst_n(rst_n), .dir(dir), .psize(psize), .msize(msize),
    .paddr(st_paddr), .maddr(st_maddr), .rd_data(rd_data),
    .capture(capture), .rd_addr(rd_addr), .rd_size(rd_size),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  // R2
  no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> st_count != '0);
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) && !step_done |=>
      $stable(st_paddr) && $stable(st_maddr) && $stable(st_count));
endmodule

// File: tb/dma_stream_tb.sv
module dma_stream_tb;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_en = 0, cfg_dir = 0, cfg_pinc = 0, cfg_minc = 0;
  logic [1:0] cfg_psize = 0, cfg_msize = 0;
  logic [AW-1:0] cfg_paddr = 0, cfg_maddr = 0;
  logic [CW-1:0] cfg_count = 0;
  logic trig = 0;
  logic rd_req, wr_req, rd_ready = 0, wr_ready = 0;
  logic [AW-1:0] rd_addr, wr_addr, st_paddr, st_maddr;
  logic [1:0] rd_size;
  logic [31:0] rd_data = 0, wr_data;
  logic [3:0] wr_be;
  logic st_en, done;
  logic [CW-1:0] st_count;

  always #2.5 clk = ~clk;

  dma_stream #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_dir(cfg_dir), .cfg_psize(cfg_psize), .cfg_msize(cfg_msize),
    .cfg_pinc(cfg_pinc), .cfg_minc(cfg_minc), .cfg_paddr(cfg_paddr),
    .cfg_maddr(cfg_maddr), .cfg_count(cfg_count), .trig(trig),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .wr_ready(wr_ready), .st_en(st_en), .st_paddr(st_paddr),
    .st_maddr(st_maddr), .st_count(st_count), .done(done)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [1:0]  sz;
    int          rem;
  } exp_t;

  exp_t rdq[$];
  exp_t wrq[$];
  int tests = 0, fails = 0;
  int rd_lat = 0, wr_lat = 0;
  int done_cnt = 0, rd_seen = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    pat = (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic int nbytes(input logic [1:0] c);
    nbytes = (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] bmask(input logic [1:0] c);
    logic [31:0] m = 0;
    for (int i = 0; i < nbytes(c); i++) m[i*8 +: 8] = 8'hFF;
    bmask = m;
  endfunction

  // responder and scoreboard monitor, all on the falling edge
  initial begin
    int rw = 0, ww = 0;
    bit prev_done = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done) begin
          done_cnt++;
          if (prev_done) check(0, "R9 done wider than one cycle", 1, 0);
        end
        prev_done = done;
        rd_ready = 0;
        if (rd_req) begin
          rd_seen++;
          if (rw >= rd_lat) begin
            rd_ready = 1;
            rd_data = pat(rd_addr);
            rw = 0;
            if (rdq.size() == 0) check(0, "R2 unexpected read", rd_addr, 0);
            else begin
              e = rdq.pop_front();
              check(rd_addr == e.addr, "R3 read address", rd_addr, e.addr);
              check(rd_size == e.sz, "R3 read size", {30'd0, rd_size}, {30'd0, e.sz});
            end
          end else rw++;
        end else rw = 0;
        wr_ready = 0;
        if (wr_req) begin
          if (ww >= wr_lat) begin
            wr_ready = 1;
            ww = 0;
            if (wrq.size() == 0) check(0, "R6 unexpected write", wr_addr, 0);
            else begin
              e = wrq.pop_front();
              check(wr_addr == e.addr, "R3 write address", wr_addr, e.addr);
              check(wr_data == e.data, "R4 write data", wr_data, e.data);
              check(wr_be == e.be, "R5 byte enables", {28'd0, wr_be}, {28'd0, e.be});
              check(st_count == CW'(e.rem), "R7 count before write",
                    32'(st_count), e.rem);
            end
          end else ww++;
        end else ww = 0;
      end
    end
  end

  task automatic cfg(input bit en, input bit dir, input logic [1:0] ps, ms,
                     input bit pi, mi, input logic [31:0] pa, ma, input int n);
    @(negedge clk);
    cfg_wr = 1; cfg_en = en; cfg_dir = dir; cfg_psize = ps; cfg_msize = ms;
    cfg_pinc = pi; cfg_minc = mi; cfg_paddr = pa; cfg_maddr = ma;
    cfg_count = CW'(n);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic run_stream(input bit dir, input logic [1:0] ps, ms,
                            input bit pi, mi, input logic [31:0] pa, ma,
                            input int n, rl, wl);
    logic [31:0] cp = pa, cm = ma, src, dst;
    logic [1:0] ssz, dsz;
    exp_t e;
    int d0, guard;
    rd_lat = rl; wr_lat = wl;
    cfg(0, dir, ps, ms, pi, mi, pa, ma, n);
    for (int i = 0; i < n; i++) begin
      src = dir ? cm : cp;  dst = dir ? cp : cm;
      ssz = dir ? ms : ps;  dsz = dir ? ps : ms;
      e.addr = src; e.sz = ssz; e.data = 0; e.be = 0; e.rem = n - i;
      rdq.push_back(e);
      e.addr = dst; e.sz = dsz;
      e.data = (pat(src) & bmask(ssz) & bmask(dsz)) << (8 * dst[1:0]);
      e.be = 4'((4'((1 << nbytes(dsz)) - 1)) << dst[1:0]);
      wrq.push_back(e);
      if (pi) cp = cp + nbytes(ps);
      if (mi) cm = cm + nbytes(ms);
    end
    d0 = done_cnt;
    cfg(1, dir, ps, ms, pi, mi, pa, ma, n);
    trig = 1;
    if (rl >= 3) begin
      guard = 0;
      while (!rd_req && guard < 50) begin @(negedge clk); guard++; end
      @(negedge clk); @(negedge clk);
      check(rd_req && !wr_req, "R6 read held before ready", {rd_req, wr_req}, 2'b10);
      check(st_count == CW'(n), "R6 count frozen while waiting", 32'(st_count), n);
    end
    guard = 0;
    while (st_en && guard < 3000) begin @(negedge clk); guard++; end
    trig = 0;
    repeat (2) @(negedge clk);
    check(!st_en, "R9 enable auto-cleared", st_en, 0);
    check(done_cnt - d0 == 1, "R9 one done pulse", done_cnt - d0, 1);
    check(st_count == 0, "R7 count reaches zero", 32'(st_count), 0);
    check(st_paddr == cp, "R8 peripheral address", st_paddr, cp);
    check(st_maddr == cm, "R8 memory address", st_maddr, cm);
    check(rdq.size() == 0 && wrq.size() == 0, "R6 all items moved",
          rdq.size() + wrq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    // R1
    check(!st_en && st_count == 0 && st_paddr == 0 && st_maddr == 0,
          "R1 reset state", {st_en, 16'(st_count)}, 0);
    check(!rd_req && !wr_req && !done, "R1 reset outputs",
          {rd_req, wr_req, done}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: disabled with pending count, trig high
    cfg(0, 1, 2'b10, 2'b10, 1, 1, 32'h100, 32'h200, 3);
    s = rd_seen; trig = 1; repeat (10) @(negedge clk); trig = 0;
    check(rd_seen == s, "R2 no read while disabled", rd_seen - s, 0);
    // R2: enabled, trig low
    cfg(1, 1, 2'b10, 2'b10, 1, 1, 32'h100, 32'h200, 3);
    repeat (10) @(negedge clk);
    check(rd_seen == s && st_count == 3, "R2 no read without trig",
          rd_seen - s, 0);
    // R10: writes while enabled only touch enable
    cfg(1, 0, 2'b00, 2'b00, 0, 0, 32'hDEAD0000, 32'hBEEF0000, 9);
    check(st_paddr == 32'h100 && st_maddr == 32'h200 && st_count == 3 && st_en,
          "R10 fields ignored while enabled", st_paddr, 32'h100);
    cfg(0, 0, 2'b00, 2'b00, 0, 0, 32'hDEAD0000, 32'hBEEF0000, 9);
    check(!st_en && st_count == 3 && st_paddr == 32'h100,
          "R10 enable clears alone", 32'(st_count), 3);
    cfg(0, 0, 2'b00, 2'b00, 0, 0, 32'hDEAD0000, 32'hBEEF0000, 9);
    check(st_paddr == 32'hDEAD0000 && st_maddr == 32'hBEEF0000 && st_count == 9,
          "R10 load while disabled", st_paddr, 32'hDEAD0000);
    // R2: enabled with zero count
    cfg(1, 1, 2'b10, 2'b10, 1, 1, 32'h300, 32'h400, 0);
    s = rd_seen; trig = 1; repeat (10) @(negedge clk); trig = 0;
    check(rd_seen == s && st_en, "R2 zero count issues nothing", rd_seen - s, 0);
    cfg(0, 1, 2'b10, 2'b10, 1, 1, 32'h300, 32'h400, 0);

    // R3 R4 R5 R8: widen byte to word, memory to peripheral
    run_stream(1, 2'b10, 2'b00, 1, 1, 32'h4000_0000, 32'h0000_1000, 4, 0, 0);
    // truncate word to byte, peripheral to memory, lanes 1,2,3,0,1
    run_stream(0, 2'b10, 2'b00, 0, 1, 32'h4000_0010, 32'h0000_2001, 5, 4, 1);
    // halfword to halfword, fixed peripheral address at lane 2
    run_stream(1, 2'b01, 2'b01, 0, 1, 32'h4000_0022, 32'h0000_3002, 3, 1, 3);
    // byte to halfword, both incrementing, reserved-free codes
    run_stream(0, 2'b00, 2'b01, 1, 1, 32'h4000_0101, 32'h0000_5002, 3, 2, 0);
    // size code 11 acts as four bytes, single item
    run_stream(0, 2'b11, 2'b11, 1, 1, 32'h4000_0200, 32'h0000_6000, 1, 0, 2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule